// File: doc/BRIEF.md
# SMM Interrupt Gating Controller

This block sits between the interrupt and trap sources of a processor core and the core's sequencer. It decides, cycle by cycle, which sources may be delivered while the core runs its system-management handler, and around the moments of entering and leaving that mode. The core reports events as one-cycle pulses: a management-mode entry, a resume (RSM), and an IRET retire. The block answers with grant pulses for NMI, maskable INTR and software interrupts. On entry it also strobes the core to clear its interrupt-enable flag, its single-step trap flag and its debug trap enables.

Once entry is accepted, NMI is held off. The block keeps a record of at most one NMI that arrives during the handler. That NMI is delivered once the hold is lifted, which happens either at resume or when an IRET retires inside the handler. After an in-handler IRET, later NMIs are delivered directly. INTR and single-step follow the flag values that the core presents. Software can therefore re-enable them inside the handler. Software interrupts are never held back.

All grants and strobes are combinational on the current inputs and the registered mode state. Every event input is a single-cycle pulse. The status outputs are registered.

Top module: `smm_irq_gate`

## Requirements
- R1: After reset, in_smm_o and nmi_pend_o are 0 and the NMI hold is clear, so an NMI rising edge in the first cycle is granted.
- R2: Outside the handler, a 0-to-1 transition of nmi_req_i grants nmi_take_o in that same cycle. A level that stays high is not granted again.
- R3: When smi_enter_i is seen while not in the handler, clr_if_o, clr_tf_o and clr_dbg_o pulse high in that cycle and in_smm_o is 1 from the next cycle. While already in the handler, smi_enter_i has no effect and produces no clear strobes.
- R4: From the entry cycle until the hold is lifted, an NMI rising edge is not granted. It sets nmi_pend_o in the next cycle.
- R5: At most one NMI is held. Further edges while nmi_pend_o is 1 are discarded, so exactly one grant follows the release.
- R6: A resume pulse (rsm_i) while in the handler returns the block to normal. A held NMI is granted in the cycle after the resume, and nmi_pend_o clears in the cycle after that grant.
- R7: An IRET pulse inside the handler lifts the NMI hold. A held NMI is granted in the next cycle, and later edges inside the handler are granted directly.
- R8: intr_take_o is granted when intr_req_i and if_flag_i are both 1. The only exceptions are an accepted-entry cycle and a cycle with an NMI grant. Setting if_flag_i again inside the handler re-enables INTR.
- R9: step_trap_o equals tf_flag_i, except that it is 0 in an accepted-entry cycle.
- R10: swint_take_o follows swint_req_i in every mode.
- R11: When an NMI grant and an INTR are both eligible in one cycle, only nmi_take_o is asserted.
- R12: in_smm_o is 1 from the cycle after an accepted entry until the cycle after a resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smi_enter_i | input | 1 | Management-mode entry event pulse |
| rsm_i | input | 1 | Resume event pulse |
| iret_i | input | 1 | IRET retire pulse |
| nmi_req_i | input | 1 | NMI request, edge-detected |
| intr_req_i | input | 1 | Maskable interrupt request level |
| swint_req_i | input | 1 | Software interrupt request |
| if_flag_i | input | 1 | Current interrupt-enable flag |
| tf_flag_i | input | 1 | Current single-step trap flag |
| nmi_take_o | output | 1 | NMI grant |
| intr_take_o | output | 1 | INTR grant |
| swint_take_o | output | 1 | Software interrupt grant |
| clr_if_o | output | 1 | Clear interrupt-enable flag strobe |
| clr_tf_o | output | 1 | Clear single-step flag strobe |
| clr_dbg_o | output | 1 | Clear debug trap enables strobe |
| step_trap_o | output | 1 | Single-step trap enable |
| in_smm_o | output | 1 | In management mode |
| nmi_pend_o | output | 1 | One NMI is held |

## Verification
The assertions assume three things about the inputs. Event inputs are single-cycle pulses. A resume and an IRET do not arrive together. The flag inputs come from the core and change only between cycles. The stimulus drives every input on the falling edge and holds each pulse for exactly one cycle. It never combines resume with IRET or entry. It also lowers nmi_req_i between requests, so that each request is a fresh rising edge.

// File: rtl/smm_gate_pkg.sv
package smm_gate_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_SMM_HOLD = 2'd1,
    MODE_SMM_OPEN = 2'd2
  } gate_mode_e;
endpackage

// File: rtl/smm_nmi_edge.sv
module smm_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= req_i;
  end
  assign rise_o = req_i & ~prev_q;
endmodule

// File: rtl/smm_mode_ctl.sv
module smm_mode_ctl
  import smm_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smi_enter_i,
  input  logic rsm_i,
  input  logic iret_i,
  output logic entry_ok_o,
  output logic nmi_blocked_o,
  output logic in_smm_o
);
  gate_mode_e mode_q, mode_d;

  assign entry_ok_o = smi_enter_i && (mode_q == MODE_NORMAL);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_NORMAL:   if (smi_enter_i) mode_d = MODE_SMM_HOLD;
      MODE_SMM_HOLD: if (rsm_i) mode_d = MODE_NORMAL;
                     else if (iret_i) mode_d = MODE_SMM_OPEN;
      MODE_SMM_OPEN: if (rsm_i) mode_d = MODE_NORMAL;
      default:       mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NORMAL;
    else        mode_q <= mode_d;
  end

  assign nmi_blocked_o = (mode_q == MODE_SMM_HOLD) || entry_ok_o;
  assign in_smm_o      = (mode_q != MODE_NORMAL);
endmodule

// File: rtl/smm_nmi_hold.sv
module smm_nmi_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic blocked_i,
  input  logic taken_i,
  output logic pend_o
);
  logic pend_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend_q <= 1'b0;
    else if (taken_i)                pend_q <= 1'b0;
    else if (rise_i && blocked_i)    pend_q <= 1'b1;
  end
  assign pend_o = pend_q;
endmodule

// File: rtl/smm_grant.sv
module smm_grant (
  input  logic nmi_rise_i,
  input  logic nmi_pend_i,
  input  logic nmi_blocked_i,
  input  logic entry_ok_i,
  input  logic intr_req_i,
  input  logic if_flag_i,
  input  logic tf_flag_i,
  input  logic swint_req_i,
  output logic nmi_take_o,
  output logic intr_take_o,
  output logic swint_take_o,
  output logic step_trap_o
);
  always_comb begin
    nmi_take_o   = !nmi_blocked_i && (nmi_pend_i || nmi_rise_i);
    intr_take_o  = intr_req_i && if_flag_i && !entry_ok_i && !nmi_take_o;
    swint_take_o = swint_req_i;
    step_trap_o  = tf_flag_i && !entry_ok_i;
  end
endmodule

// File: rtl/smm_irq_gate.sv
module smm_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_enter_i,
  input  logic rsm_i,
  input  logic iret_i,
  input  logic nmi_req_i,
  input  logic intr_req_i,
  input  logic swint_req_i,
  input  logic if_flag_i,
  input  logic tf_flag_i,
  output logic nmi_take_o,
  output logic intr_take_o,
  output logic swint_take_o,
  output logic clr_if_o,
  output logic clr_tf_o,
  output logic clr_dbg_o,
  output logic step_trap_o,
  output logic in_smm_o,
  output logic nmi_pend_o
);
  logic nmi_rise, entry_ok, nmi_blocked;

  smm_nmi_edge u_edge (
    .clk(clk), .rst_n(rst_n), .req_i(nmi_req_i), .rise_o(nmi_rise)
  );

  smm_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .smi_enter_i(smi_enter_i), .rsm_i(rsm_i),
    .iret_i(iret_i), .entry_ok_o(entry_ok), .nmi_blocked_o(nmi_blocked),
    .in_smm_o(in_smm_o)
  );

  smm_nmi_hold u_hold (
    .clk(clk), .rst_n(rst_n), .rise_i(nmi_rise), .blocked_i(nmi_blocked),
    .taken_i(nmi_take_o), .pend_o(nmi_pend_o)
  );

  smm_grant u_grant (
    .nmi_rise_i(nmi_rise), .nmi_pend_i(nmi_pend_o),
    .nmi_blocked_i(nmi_blocked), .entry_ok_i(entry_ok),
    .intr_req_i(intr_req_i), .if_flag_i(if_flag_i), .tf_flag_i(tf_flag_i),
    .swint_req_i(swint_req_i), .nmi_take_o(nmi_take_o),
    .intr_take_o(intr_take_o), .swint_take_o(swint_take_o),
    .step_trap_o(step_trap_o)
  );

  assign clr_if_o  = entry_ok;
  assign clr_tf_o  = entry_ok;
  assign clr_dbg_o = entry_ok;
endmodule

// File: rtl/smm_irq_gate_chk.sv
module smm_irq_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic smi_enter_i,
  input logic rsm_i,
  input logic iret_i,
  input logic intr_req_i,
  input logic if_flag_i,
  input logic swint_req_i,
  input logic nmi_take_o,
  input logic intr_take_o,
  input logic swint_take_o,
  input logic clr_if_o,
  input logic clr_tf_o,
  input logic clr_dbg_o,
  input logic in_smm_o,
  input logic nmi_pend_o
);
  assert_entry_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_enter_i && !in_smm_o) |-> (clr_if_o && clr_tf_o && clr_dbg_o));

  assert_entry_sets_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_enter_i && !in_smm_o) |=> in_smm_o);

  assert_no_nmi_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_enter_i && !in_smm_o) |-> !nmi_take_o);

  assert_pend_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_o && !nmi_take_o) |=> nmi_pend_o);

  assert_pend_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take_o |=> !nmi_pend_o);

  assert_resume_delivers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smm_o && rsm_i && nmi_pend_o) |=> nmi_take_o);

  assert_iret_delivers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smm_o && iret_i && !rsm_i && nmi_pend_o) |=> nmi_take_o);

  assert_nmi_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_take_o && intr_take_o));

  assert_intr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    intr_take_o |-> (intr_req_i && if_flag_i));

  assert_swint_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    swint_req_i |-> swint_take_o);
endmodule

bind smm_irq_gate smm_irq_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smi_enter_i(smi_enter_i), .rsm_i(rsm_i),
  .iret_i(iret_i), .intr_req_i(intr_req_i), .if_flag_i(if_flag_i),
  .swint_req_i(swint_req_i), .nmi_take_o(nmi_take_o),
  .intr_take_o(intr_take_o), .swint_take_o(swint_take_o),
  .clr_if_o(clr_if_o), .clr_tf_o(clr_tf_o), .clr_dbg_o(clr_dbg_o),
  .in_smm_o(in_smm_o), .nmi_pend_o(nmi_pend_o)
);

// File: tb/smm_irq_gate_tb.sv
module smm_irq_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smi, rsm, iret, nmi, intr, swi, ifl, tf;
  logic nmi_take, intr_take, swint_take, clr_if, clr_tf, clr_dbg, step_trap, in_smm, pend;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [8:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_irq_gate u_dut (
    .clk(clk), .rst_n(rst_n), .smi_enter_i(smi), .rsm_i(rsm), .iret_i(iret),
    .nmi_req_i(nmi), .intr_req_i(intr), .swint_req_i(swi), .if_flag_i(ifl),
    .tf_flag_i(tf), .nmi_take_o(nmi_take), .intr_take_o(intr_take),
    .swint_take_o(swint_take), .clr_if_o(clr_if), .clr_tf_o(clr_tf),
    .clr_dbg_o(clr_dbg), .step_trap_o(step_trap), .in_smm_o(in_smm),
    .nmi_pend_o(pend)
  );

  // in = {smi,rsm,iret,nmi,intr,swi,ifl,tf}
  // exp = {nmi_take,intr_take,swint_take,clr,step_trap,in_smm,pend}
  task automatic step(input logic [7:0] in, input logic [6:0] e, input string tag);
    item_t it;
    @(negedge clk);
    {smi, rsm, iret, nmi, intr, swi, ifl, tf} = in;
    it.exp = {e[6:4], e[3], e[3], e[3], e[2:0]};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        item_t it;
        logic [8:0] act;
        it = sb_q.pop_front();
        act = {nmi_take, intr_take, swint_take, clr_if, clr_tf, clr_dbg, step_trap, in_smm, pend};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    {smi, rsm, iret, nmi, intr, swi, ifl, tf} = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(8'b0000_0000, 7'b000_0000, "R1 idle after reset");
    step(8'b0001_0000, 7'b100_0000, "R2 nmi edge outside");
    step(8'b0001_0000, 7'b000_0000, "R2 held level no regrant");
    step(8'b0000_1110, 7'b011_0000, "R8 R10 intr and swint outside");
    step(8'b0001_1010, 7'b100_0000, "R11 nmi beats intr");
    step(8'b1000_1011, 7'b000_1000, "R3 R8 R9 entry strobes, intr and step off");
    step(8'b0000_0001, 7'b000_0110, "R9 R12 tf honoured in smm");
    step(8'b1000_0000, 7'b000_0010, "R3 entry ignored in smm");
    step(8'b0001_0000, 7'b000_0010, "R4 nmi held off");
    step(8'b0000_0000, 7'b000_0011, "R4 nmi pending");
    step(8'b0001_0000, 7'b000_0011, "R5 second nmi discarded");
    step(8'b0000_0100, 7'b001_0011, "R10 swint in smm");
    step(8'b0000_1010, 7'b010_0011, "R8 intr after if set in smm");
    step(8'b0100_0000, 7'b000_0011, "R6 resume cycle");
    step(8'b0000_0000, 7'b100_0001, "R6 R12 held nmi after resume");
    step(8'b0000_0000, 7'b000_0000, "R5 single grant, pend cleared");
    step(8'b1000_0000, 7'b000_1000, "R3 second entry");
    step(8'b0001_0000, 7'b000_0010, "R4 nmi held again");
    step(8'b0010_0000, 7'b000_0011, "R7 iret cycle");
    step(8'b0000_0000, 7'b100_0011, "R7 held nmi after iret");
    step(8'b0001_0000, 7'b100_0010, "R7 direct nmi in smm");
    step(8'b0100_0000, 7'b000_0010, "R12 resume");
    step(8'b0000_0000, 7'b000_0000, "R12 left smm");
    step(8'b1000_0000, 7'b000_1000, "R3 entry before reset");
    step(8'b0001_0000, 7'b000_0010, "R4 nmi before reset");
    step(8'b0000_0000, 7'b000_0011, "R4 pend before reset");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(8'b0000_0000, 7'b000_0000, "R1 state cleared by reset");
    step(8'b0001_0000, 7'b100_0000, "R1 hold cleared by reset");
    step(8'b0000_0000, 7'b000_0000, "R1 quiet");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule